// File: doc/BRIEF.md
# Cache Way Lock Controller

This block keeps the tag, valid and lock state of a small set-associative cache directory and decides which way a refill may overwrite. Software-visible cache maintenance reaches it as requests of four kinds: a refill (fill) that installs a tag, a lock request, an unlock request and an invalidate that also drops the lock. Each request names a set index and a tag. One cycle later the block answers with a status bit, the way the request touched, and the mask of ways in that set that replacement may still evict.

A lock is a request, not a command: it is granted only when the line is resident and at least one other way of the set stays unlocked. A set therefore can never become fully locked, and a refill always finds a way it may evict. Locking can be removed at build time, after which every lock request is refused. Victim choice takes an invalid way when one exists, and otherwise a per-set round-robin pointer that steps over locked ways.

Top module: `cwl_ctrl`

## Requirements
- R1: After reset every line is invalid and unlocked, `rsp_valid` is 0 and `evict_mask` is all ones.
- R2: Each request accepted with `req_valid` high produces exactly one response, with `rsp_valid` high in the cycle after the accepting clock edge; requests may be issued back to back. Op encoding: 2'b00 fill, 2'b01 lock, 2'b10 unlock, 2'b11 invalidate.
- R3: A fill whose tag is resident answers ok with that way and changes nothing; a fill that misses installs the tag, valid and unlocked, in the victim way and answers ok with that way.
- R4: The fill victim is the lowest-numbered invalid way; when all ways are valid it is the first unlocked way found scanning upward (with wrap) from the set's pointer; after every missing fill the set's pointer becomes victim + 1, modulo the way count.
- R5: A lock of a resident, unlocked line succeeds (ok = 1, way = its way) when at least one other way of the set stays unlocked afterwards.
- R6: A lock that would leave no unlocked way in the set answers ok = 0 and changes no state; no set ever has all ways locked.
- R7: A lock of a tag that is not resident answers ok = 0, way = 0, and installs nothing.
- R8: Locking a line that is already locked answers ok = 1 and changes nothing.
- R9: With `LOCK_EN` = 0 every lock request answers ok = 0 and no lock bit is ever set.
- R10: An unlock of a resident line clears its lock bit and answers ok = 1; an unlock of a non-resident tag answers ok = 0 and has no effect; unlocking an unlocked line changes nothing.
- R11: An invalidate of a resident line clears both its valid and lock bits and answers ok = 1; an invalidate that misses answers ok = 0 and changes nothing.
- R12: In the response cycle `evict_mask` holds, for the set of that request, a 1 for every way not locked after the request took effect. For all non-fill misses `rsp_way` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per high cycle |
| req_op | input | 2 | Operation: 0 fill, 1 lock, 2 unlock, 3 invalidate |
| req_set | input | $clog2(SETS) | Set index |
| req_tag | input | TAG_W | Line tag |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Status: success / line present |
| rsp_way | output | $clog2(WAYS) | Way hit, filled, or 0 |
| evict_mask | output | WAYS | Ways of the responded set that may be evicted |

## Verification
The bench builds two instances side by side from one request stream: one with the defaults (4 sets, 4 ways, 8-bit tags, locking on) and one with `LOCK_EN` = 0. Four ways make it possible to reach the refusal of the last unlocked way in a handful of requests and to watch the round-robin pointer wrap past several locked ways. The locking-disabled copy then sees the same locks refused while its victim order diverges, and a long stretch of requests over a small tag range keeps hits, misses and relocks frequent.

// File: rtl/cwl_pkg.sv
package cwl_pkg;

    typedef enum logic [1:0] {
        CWL_FILL   = 2'b00,
        CWL_LOCK   = 2'b01,
        CWL_UNLOCK = 2'b10,
        CWL_INVAL  = 2'b11
    } cwl_op_e;

endpackage

// File: rtl/cwl_tag_match.sv
module cwl_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    // Per-way comparators
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == tag);
    end

    // Lowest matching way (at most one matches in a consistent directory)
    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cwl_victim_pick.sv
module cwl_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  lock,
    input  logic [WAY_W-1:0] ptr,
    output logic [WAY_W-1:0] victim,
    output logic [WAY_W-1:0] ptr_next
);
    logic [WAY_W-1:0] inv_way;
    logic             inv_found;
    logic [WAY_W-1:0] rr_way;
    logic             rr_found;

    // Lowest invalid way
    always_comb begin
        inv_way   = '0;
        inv_found = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                inv_way   = WAY_W'(w);
                inv_found = 1'b1;
            end
        end
    end

    // Round-robin scan from ptr, stepping over locked ways
    always_comb begin
        rr_way   = ptr;
        rr_found = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            logic [WAY_W-1:0] idx;
            idx = ptr + WAY_W'(i);
            if (!rr_found && !lock[idx]) begin
                rr_way   = idx;
                rr_found = 1'b1;
            end
        end
    end

    assign victim   = inv_found ? inv_way : rr_way;
    assign ptr_next = victim + WAY_W'(1);
endmodule

// File: rtl/cwl_lock_policy.sv
module cwl_lock_policy #(
    parameter int WAYS    = 4,
    parameter bit LOCK_EN = 1'b1,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             hit,
    input  logic [WAY_W-1:0] hit_way,
    input  logic [WAYS-1:0]  lock,
    output logic             grant,
    output logic             set_bit
);
    if (LOCK_EN) begin : g_lock
        logic [WAY_W:0] n_locked;
        logic           already;
        always_comb begin
            n_locked = '0;
            for (int w = 0; w < WAYS; w++) begin
                n_locked = n_locked + (WAY_W+1)'(lock[w]);
            end
        end
        assign already = hit && lock[hit_way];
        // Grant if already held, or if one unlocked way remains afterwards
        assign set_bit = hit && !already && (n_locked < (WAY_W+1)'(WAYS - 1));
        assign grant   = already || set_bit;
    end else begin : g_nolock
        assign grant   = 1'b0;
        assign set_bit = 1'b0;
    end
endmodule

// File: rtl/cwl_ctrl.sv
module cwl_ctrl #(
    parameter int SETS    = 4,
    parameter int WAYS    = 4,
    parameter int TAG_W   = 8,
    parameter bit LOCK_EN = 1'b1,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [SET_W-1:0] req_set,
    input  logic [TAG_W-1:0] req_tag,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic [WAY_W-1:0] rsp_way,
    output logic [WAYS-1:0]  evict_mask
);
    import cwl_pkg::*;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            valid;
        logic [SETS-1:0][WAYS-1:0]            lock;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAY_W-1:0]           ptr;
        logic                                 rsp_valid;
        logic                                 rsp_ok;
        logic                                 rsp_hit;
        logic [1:0]                           rsp_op;
        logic [WAY_W-1:0]                     rsp_way;
        logic [SET_W-1:0]                     rsp_set;
    } state_t;

    state_t s_q, s_d;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;
    logic [WAY_W-1:0] ptr_next;
    logic             lk_grant;
    logic             lk_set;

    cwl_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .valid   (s_q.valid[req_set]),
        .tags    (s_q.tag[req_set]),
        .tag     (req_tag),
        .hit     (hit),
        .hit_way (hit_way)
    );

    cwl_victim_pick #(.WAYS(WAYS)) u_victim (
        .valid    (s_q.valid[req_set]),
        .lock     (s_q.lock[req_set]),
        .ptr      (s_q.ptr[req_set]),
        .victim   (victim),
        .ptr_next (ptr_next)
    );

    cwl_lock_policy #(.WAYS(WAYS), .LOCK_EN(LOCK_EN)) u_policy (
        .hit     (hit),
        .hit_way (hit_way),
        .lock    (s_q.lock[req_set]),
        .grant   (lk_grant),
        .set_bit (lk_set)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = req_valid;
        if (req_valid) begin
            s_d.rsp_op  = req_op;
            s_d.rsp_set = req_set;
            s_d.rsp_hit = hit;
            s_d.rsp_way = hit ? hit_way : '0;
            s_d.rsp_ok  = 1'b0;
            unique case (cwl_op_e'(req_op))
                CWL_FILL: begin
                    s_d.rsp_ok = 1'b1;
                    if (!hit) begin
                        s_d.rsp_way                  = victim;
                        s_d.valid[req_set][victim]   = 1'b1;
                        s_d.lock[req_set][victim]    = 1'b0;
                        s_d.tag[req_set][victim]     = req_tag;
                        s_d.ptr[req_set]             = ptr_next;
                    end
                end
                CWL_LOCK: begin
                    s_d.rsp_ok = lk_grant;
                    if (lk_set) s_d.lock[req_set][hit_way] = 1'b1;
                end
                CWL_UNLOCK: begin
                    s_d.rsp_ok = hit;
                    if (hit) s_d.lock[req_set][hit_way] = 1'b0;
                end
                CWL_INVAL: begin
                    s_d.rsp_ok = hit;
                    if (hit) begin
                        s_d.valid[req_set][hit_way] = 1'b0;
                        s_d.lock[req_set][hit_way]  = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid  = s_q.rsp_valid;
    assign rsp_ok     = s_q.rsp_ok;
    assign rsp_way    = s_q.rsp_way;
    assign evict_mask = ~s_q.lock[s_q.rsp_set];

    // R6: no set ever has every way locked
    for (genvar g = 0; g < SETS; g++) begin : g_sva_set
        a_r6_never_full: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(s_q.lock[g]) < WAYS);
        // R11: a lock bit only exists on a valid line
        a_r11_lock_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.lock[g] & ~s_q.valid[g]) == '0);
    end

    // R9: with locking removed no lock bit ever appears
    if (!LOCK_EN) begin : g_sva_nolock
        a_r9_no_lock_bits: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.lock == '0);
    end

    // R3/R4: a missing fill lands on a valid, unlocked way holding the new tag
    a_r3_fill_lands_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rsp_valid && s_q.rsp_op == CWL_FILL && !s_q.rsp_hit) |->
            (s_q.valid[s_q.rsp_set][s_q.rsp_way] && !s_q.lock[s_q.rsp_set][s_q.rsp_way]));

    // R5: a granted lock leaves the line locked
    a_r5_lock_ok_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rsp_valid && s_q.rsp_op == CWL_LOCK && s_q.rsp_ok) |->
            s_q.lock[s_q.rsp_set][s_q.rsp_way]);

    // R10: a successful unlock leaves the line unlocked
    a_r10_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rsp_valid && s_q.rsp_op == CWL_UNLOCK && s_q.rsp_ok) |->
            !s_q.lock[s_q.rsp_set][s_q.rsp_way]);

    // R11: a successful invalidate drops valid and lock
    a_r11_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rsp_valid && s_q.rsp_op == CWL_INVAL && s_q.rsp_ok) |->
            (!s_q.valid[s_q.rsp_set][s_q.rsp_way] && !s_q.lock[s_q.rsp_set][s_q.rsp_way]));

    // R2: one response per request, one cycle later
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
endmodule

// File: tb/cwl_ctrl_tb.sv
`timescale 1ns/1ps
module cwl_ctrl_tb;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;
    localparam int TAG_W = 8;
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [SET_W-1:0] req_set = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic r0_valid, r0_ok, r1_valid, r1_ok;
    logic [WAY_W-1:0] r0_way, r1_way;
    logic [WAYS-1:0] r0_mask, r1_mask;

    always #4 clk = ~clk;

    cwl_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LOCK_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_set(req_set), .req_tag(req_tag), .rsp_valid(r0_valid),
        .rsp_ok(r0_ok), .rsp_way(r0_way), .evict_mask(r0_mask));

    cwl_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LOCK_EN(1'b0)) u_nolock (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_set(req_set), .req_tag(req_tag), .rsp_valid(r1_valid),
        .rsp_ok(r1_ok), .rsp_way(r1_way), .evict_mask(r1_mask));

    typedef struct {
        string           rq;
        bit              ok;
        int              way;
        bit [WAYS-1:0]   mask;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];
    int checks = 0;
    int errors = 0;
    int n_req = 0;
    int n_rsp0 = 0;
    int n_rsp1 = 0;
    bit done = 0;

    // Reference directory per instance (0 = locking on, 1 = off)
    bit mv [2][SETS][WAYS];
    bit ml [2][SETS][WAYS];
    int mt [2][SETS][WAYS];
    int mp [2][SETS];

    function automatic exp_t model(int m, int op, int s, int t, string rq);
        exp_t e;
        bit hit = 0;
        int hw = 0;
        int v;
        int cnt;
        bit found;
        e.rq = rq;
        for (int w = 0; w < WAYS; w++)
            if (!hit && mv[m][s][w] && mt[m][s][w] == t) begin hit = 1; hw = w; end
        e.way = hit ? hw : 0;
        e.ok = 0;
        case (op)
            0: begin
                e.ok = 1;
                if (!hit) begin
                    found = 0; v = 0;
                    for (int w = 0; w < WAYS; w++)
                        if (!found && !mv[m][s][w]) begin found = 1; v = w; end
                    for (int i = 0; i < WAYS; i++)
                        if (!found && !ml[m][s][(mp[m][s] + i) % WAYS]) begin
                            found = 1; v = (mp[m][s] + i) % WAYS;
                        end
                    mv[m][s][v] = 1; ml[m][s][v] = 0; mt[m][s][v] = t;
                    mp[m][s] = (v + 1) % WAYS;
                    e.way = v;
                end
            end
            1: begin
                if (m == 1 || !hit) e.ok = 0;
                else if (ml[m][s][hw]) e.ok = 1;
                else begin
                    cnt = 0;
                    for (int w = 0; w < WAYS; w++) cnt += int'(ml[m][s][w]);
                    if (cnt == WAYS - 1) e.ok = 0;
                    else begin ml[m][s][hw] = 1; e.ok = 1; end
                end
            end
            2: begin
                e.ok = hit;
                if (hit) ml[m][s][hw] = 0;
            end
            default: begin
                e.ok = hit;
                if (hit) begin mv[m][s][hw] = 0; ml[m][s][hw] = 0; end
            end
        endcase
        for (int w = 0; w < WAYS; w++) e.mask[w] = !ml[m][s][w];
        return e;
    endfunction

    task automatic do_op(int op, int s, int t, string rq);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_set   = SET_W'(s);
        req_tag   = TAG_W'(t);
        q0.push_back(model(0, op, s, t, rq));
        q1.push_back(model(1, op, s, t, (op == 1) ? "R9" : rq));
        n_req++;
    endtask

    task automatic check_rsp(int inst, exp_t e, logic ok, logic [WAY_W-1:0] way,
                             logic [WAYS-1:0] mask);
        checks++;
        if (ok !== e.ok || int'(way) != e.way) begin
            errors++;
            $display("FAIL %s inst%0d: ok/way actual %0b/%0d expected %0b/%0d",
                     e.rq, inst, ok, way, e.ok, e.way);
        end
        checks++;
        if (mask !== e.mask) begin
            errors++;
            $display("FAIL R12 (%s) inst%0d: evict_mask actual %b expected %b",
                     e.rq, inst, mask, e.mask);
        end
    endtask

    // Monitor: scoreboard pops
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (r0_valid) begin
                n_rsp0++;
                if (q0.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 inst0: response with no request, actual 1 expected 0");
                end else check_rsp(0, q0.pop_front(), r0_ok, r0_way, r0_mask);
            end
            if (r1_valid) begin
                n_rsp1++;
                if (q1.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 inst1: response with no request, actual 1 expected 0");
                end else check_rsp(1, q1.pop_front(), r1_ok, r1_way, r1_mask);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < SETS; s++) begin
                mp[m][s] = 0;
                for (int w = 0; w < WAYS; w++) begin
                    mv[m][s][w] = 0; ml[m][s][w] = 0; mt[m][s][w] = 0;
                end
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (r0_valid !== 1'b0 || r0_mask !== '1) begin
            errors++;
            $display("FAIL R1: valid/mask actual %0b/%b expected 0/%b", r0_valid, r0_mask, {WAYS{1'b1}});
        end

        // R1/R4: fill an empty set, invalid ways in order
        do_op(0, 0, 8'h10, "R4");
        do_op(0, 0, 8'h11, "R4");
        do_op(0, 0, 8'h12, "R4");
        do_op(0, 0, 8'h13, "R4");
        do_op(0, 0, 8'h10, "R3");        // fill hit
        do_op(1, 0, 8'h10, "R5");
        do_op(1, 0, 8'h11, "R5");
        do_op(1, 0, 8'h12, "R5");
        do_op(1, 0, 8'h13, "R6");        // last unlocked way refused
        do_op(1, 0, 8'h11, "R8");        // relock
        do_op(1, 0, 8'h55, "R7");        // absent line
        do_op(0, 0, 8'h20, "R4");        // skips locked ways to way 3
        do_op(0, 0, 8'h21, "R4");        // pointer wraps, way 3 again
        do_op(2, 0, 8'h11, "R10");
        do_op(2, 0, 8'h11, "R10");       // unlock of unlocked line
        do_op(2, 0, 8'h77, "R10");       // unlock of absent line
        do_op(0, 0, 8'h22, "R4");        // round robin lands on way 1
        do_op(3, 0, 8'h12, "R11");       // invalidate a locked line
        do_op(0, 0, 8'h23, "R4");        // invalid way preferred
        do_op(1, 0, 8'h23, "R5");
        do_op(1, 0, 8'h22, "R5");
        do_op(1, 0, 8'h21, "R6");
        do_op(3, 0, 8'h99, "R11");       // invalidate miss
        do_op(1, 0, 8'h55, "R7");        // still absent after R7 above
        do_op(0, 3, 8'h05, "R3");
        do_op(1, 3, 8'h05, "R5");
        do_op(3, 3, 8'h05, "R11");
        do_op(1, 3, 8'h05, "R7");

        // Mixed stream over a small tag range
        for (int i = 0; i < 1500; i++) begin
            int op;
            op = int'($urandom_range(0, 3));
            do_op(op, int'($urandom_range(0, SETS - 1)), int'($urandom_range(0, 7)),
                  (op == 0) ? "R3/R4" : (op == 1) ? "R5/R6/R8" : (op == 2) ? "R10" : "R11");
        end

        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R2: every request answered exactly once
        checks++;
        if (n_rsp0 != n_req || n_rsp1 != n_req || q0.size() != 0 || q1.size() != 0) begin
            errors++;
            $display("FAIL R2: responses actual %0d/%0d expected %0d", n_rsp0, n_rsp1, n_req);
        end
        finish_run();
    end
endmodule